// File: doc/BRIEF.md
# Commutation-Aware Six-Switch PWM Generator

This block drives the six gate chop signals of a three-phase brushless DC inverter, one high-side and one low-side signal per phase. A free-running carrier counter with a programmable period sets the switching period; at the default period and a 250 MHz clock it gives 12,500 ticks per carrier period, which is a 50 µs period and a 20 kHz switching rate. Each cycle the carrier is compared with an on-time to form a chop level. A Hall-derived sector code in the range 1 to 6 then selects which switches that chop level drives.

Outside commutation (`comm_i` low) the block chops only two phases. It uses the normal on-time from the outer loop: the high-side switch of the sector's source phase follows the chop level, and the low-side switch of its sink phase stays on. While `comm_i` is high it moves to three-phase chopping, so that the incoming and outgoing phase currents change at the same rate with opposite sign. The even and odd sector groups each have their own commutation on-time.

The period and all on-times are shadowed and loaded only when the carrier wraps, so a change made part-way through a period cannot produce a runt pulse. The sector code and the commutation flag act at once, because the commutation detector needs the switch pattern to follow it on the next cycle. A one-cycle strobe marks every change of the chop level, so a downstream comparator can skip samples taken near switching instants.

Top module: `bldc_chop_gen`

## Requirements
- R1: `cnt_o` steps by one each cycle from 0 to P-1 and then returns to 0, where P is the shadowed period. A shadowed period of 0 or 1 holds `cnt_o` at 0.
- R2: The shadowed period and the three shadowed on-times load from `period_i`, `ton_norm_i`, `ton_comm_even_i` and `ton_comm_odd_i` only on a cycle whose `cnt_o` equals P-1 (or 0 when P is 0 or 1). After reset they hold `RST_PERIOD` and 0.
- R3: The chop level is 1 when the carrier value is below the selected on-time. The selected on-time is the normal one when `comm_i` is 0. When `comm_i` is 1 it is the even on-time if `sector_i[0]` is 0 and the odd on-time otherwise. The gate outputs in the cycle after a clock edge reflect the carrier value `cnt_o` held before that edge. An on-time of 0 never chops on, and an on-time of P or more always chops on.
- R4: Phase index 0 is A, 1 is B and 2 is C on bit positions of `gate_hi_o` and `gate_lo_o`. Each sector has a source phase and a sink phase: sector 1 A and B, sector 2 A and C, sector 3 B and C, sector 4 B and A, sector 5 C and A, sector 6 C and B. With `comm_i` at 0, the source high-side signal equals the chop level, the sink low-side signal is 1, and every other gate is 0.
- R5: With `comm_i` at 1 in sectors 2, 4 and 6, the source high-side signal and the low-side signal of the previous sector's sink phase equal the chop level. The current sink low-side signal is 1 and the others are 0. The previous sector of 1 is 6.
- R6: With `comm_i` at 1 in sectors 1, 3 and 5, the sink low-side signal and the high-side signal of the previous sector's source phase equal the chop level. The current source high-side signal is 1 and the others are 0.
- R7: A `sector_i` of 0 or 7 drives all six gates to 0 in the next cycle, and reset drives all six gates to 0.
- R8: The high-side and low-side signals of any one phase are never 1 together.
- R9: `chop_edge_o` is 1 for exactly those cycles in which the chop level behind the gate outputs differs from that of the previous cycle. The chop level is taken as 0 before the first cycle after reset, and the strobe works for any sector code.
- R10: A change of `sector_i` or `comm_i` alters the gate pattern in the next cycle, without waiting for a carrier wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | CNT_W | Carrier period in ticks, shadowed at wrap |
| sector_i | input | 3 | Hall sector code, 1..6 valid |
| comm_i | input | 1 | Commutation period flag |
| ton_norm_i | input | CNT_W | Two-phase on-time in ticks |
| ton_comm_even_i | input | CNT_W | Commutation on-time for sectors 2, 4, 6 |
| ton_comm_odd_i | input | CNT_W | Commutation on-time for sectors 1, 3, 5 |
| cnt_o | output | CNT_W | Carrier count |
| gate_hi_o | output | 3 | High-side chop signals, bit 0 = A |
| gate_lo_o | output | 3 | Low-side chop signals, bit 0 = A |
| chop_edge_o | output | 1 | One-cycle strobe on each chop level change |

## Verification
A wrong carrier or shadow state shows up within a single carrier period. It appears as a pulse width that differs from the on-time latched at the previous wrap, or as a `cnt_o` sequence that skips or overruns. A wrong phase role shows at the gate ports on the cycle right after a sector or commutation-flag change, so the bench walks every sector in both modes and compares the full six-bit pattern each cycle. A stale chop history shows as a strobe that is missing or extra on that same cycle.

// File: rtl/bldc_chop_pkg.sv
package bldc_chop_pkg;

  localparam int NPH = 3;

  typedef enum logic [2:0] {
    ROLE_IDLE,
    ROLE_HI_CHOP,
    ROLE_HI_ON,
    ROLE_LO_CHOP,
    ROLE_LO_ON
  } role_e;

  function automatic logic sector_ok(input logic [2:0] s);
    return (s != 3'd0) && (s != 3'd7);
  endfunction

  // source phase of a sector (high side conducts)
  function automatic logic [1:0] src_phase(input logic [2:0] s);
    case (s)
      3'd1, 3'd2: return 2'd0;
      3'd3, 3'd4: return 2'd1;
      default:    return 2'd2;
    endcase
  endfunction

  // sink phase of a sector (low side conducts)
  function automatic logic [1:0] snk_phase(input logic [2:0] s);
    case (s)
      3'd1:       return 2'd1;
      3'd2, 3'd3: return 2'd2;
      3'd4, 3'd5: return 2'd0;
      default:    return 2'd1;
    endcase
  endfunction

  function automatic logic [2:0] prev_sector(input logic [2:0] s);
    return (s == 3'd1) ? 3'd6 : s - 3'd1;
  endfunction

  function automatic role_e phase_role(input logic [1:0] p, input logic [2:0] s,
                                       input logic comm);
    logic [2:0] ps;
    ps = prev_sector(s);
    if (!sector_ok(s)) return ROLE_IDLE;
    if (!comm) begin
      if (p == src_phase(s)) return ROLE_HI_CHOP;
      if (p == snk_phase(s)) return ROLE_LO_ON;
      return ROLE_IDLE;
    end
    if (!s[0]) begin
      // source held, old sink chopped off, new sink on
      if (p == src_phase(s))  return ROLE_HI_CHOP;
      if (p == snk_phase(ps)) return ROLE_LO_CHOP;
      if (p == snk_phase(s))  return ROLE_LO_ON;
    end else begin
      // sink held, old source chopped, new source on
      if (p == snk_phase(s))  return ROLE_LO_CHOP;
      if (p == src_phase(ps)) return ROLE_HI_CHOP;
      if (p == src_phase(s))  return ROLE_HI_ON;
    end
    return ROLE_IDLE;
  endfunction

endpackage

// File: rtl/bldc_carrier.sv
module bldc_carrier #(
  parameter int CNT_W      = 16,
  parameter int RST_PERIOD = 12500
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] RST_P = CNT_W'(RST_PERIOD);

  logic [CNT_W-1:0] cnt_q, period_q, last_c;

  assign last_c = (period_q == '0) ? '0 : period_q - CNT_W'(1);
  assign wrap_o = (cnt_q == last_c);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      period_q <= RST_P;
    end else if (wrap_o) begin
      cnt_q    <= '0;
      period_q <= period_i;
    end else begin
      cnt_q    <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/bldc_duty_sel.sv
module bldc_duty_sel #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [2:0]       sector_i,
  input  logic             comm_i,
  input  logic [CNT_W-1:0] ton_norm_i,
  input  logic [CNT_W-1:0] ton_comm_even_i,
  input  logic [CNT_W-1:0] ton_comm_odd_i,
  output logic             chop_o
);

  localparam int NSH = 3;

  logic [NSH-1:0][CNT_W-1:0] ton_in, ton_q;
  logic [CNT_W-1:0]          ton_sel;

  assign ton_in = {ton_comm_odd_i, ton_comm_even_i, ton_norm_i};

  // per-slot shadow registers, loaded only at carrier wrap
  for (genvar i = 0; i < NSH; i++) begin : g_shadow
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ton_q[i] <= '0;
      else if (wrap_i) ton_q[i] <= ton_in[i];
    end
  end

  always_comb begin
    if (!comm_i)          ton_sel = ton_q[0];
    else if (!sector_i[0]) ton_sel = ton_q[1];
    else                  ton_sel = ton_q[2];
  end

  assign chop_o = (cnt_i < ton_sel);

endmodule

// File: rtl/bldc_phase_map.sv
module bldc_phase_map
  import bldc_chop_pkg::*;
(
  input  logic           chop_i,
  input  logic [2:0]     sector_i,
  input  logic           comm_i,
  output logic [NPH-1:0] hi_o,
  output logic [NPH-1:0] lo_o
);

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    role_e role;
    assign role = phase_role(2'(p), sector_i, comm_i);
    always_comb begin
      hi_o[p] = 1'b0;
      lo_o[p] = 1'b0;
      case (role)
        ROLE_HI_CHOP: hi_o[p] = chop_i;
        ROLE_HI_ON:   hi_o[p] = 1'b1;
        ROLE_LO_CHOP: lo_o[p] = chop_i;
        ROLE_LO_ON:   lo_o[p] = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/bldc_chop_gen.sv
module bldc_chop_gen
  import bldc_chop_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int RST_PERIOD = 12500
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic [2:0]       sector_i,
  input  logic             comm_i,
  input  logic [CNT_W-1:0] ton_norm_i,
  input  logic [CNT_W-1:0] ton_comm_even_i,
  input  logic [CNT_W-1:0] ton_comm_odd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [2:0]       gate_hi_o,
  output logic [2:0]       gate_lo_o,
  output logic             chop_edge_o
);

  logic           wrap, chop_c, chop_q, edge_q;
  logic [NPH-1:0] hi_c, lo_c, hi_q, lo_q;

  bldc_carrier #(.CNT_W(CNT_W), .RST_PERIOD(RST_PERIOD)) u_carrier (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .period_i (period_i),
    .cnt_o    (cnt_o),
    .wrap_o   (wrap)
  );

  bldc_duty_sel #(.CNT_W(CNT_W)) u_duty (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .wrap_i          (wrap),
    .cnt_i           (cnt_o),
    .sector_i        (sector_i),
    .comm_i          (comm_i),
    .ton_norm_i      (ton_norm_i),
    .ton_comm_even_i (ton_comm_even_i),
    .ton_comm_odd_i  (ton_comm_odd_i),
    .chop_o          (chop_c)
  );

  bldc_phase_map u_map (
    .chop_i   (chop_c),
    .sector_i (sector_i),
    .comm_i   (comm_i),
    .hi_o     (hi_c),
    .lo_o     (lo_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      lo_q   <= '0;
      chop_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      hi_q   <= hi_c;
      lo_q   <= lo_c;
      chop_q <= chop_c;
      edge_q <= chop_c ^ chop_q;
    end
  end

  assign gate_hi_o   = hi_q;
  assign gate_lo_o   = lo_q;
  assign chop_edge_o = edge_q;

endmodule

// File: rtl/bldc_chop_chk.sv
module bldc_chop_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       sector_i,
  input logic             comm_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic [2:0]       gate_hi_o,
  input logic [2:0]       gate_lo_o
);

  assert_no_shoot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_hi_o & gate_lo_o) == 3'b000);

  assert_bad_sector_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sector_i == 3'd0 || sector_i == 3'd7) |=> (gate_hi_o == 3'b000 && gate_lo_o == 3'b000));

  assert_carrier_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o != '0) |-> (cnt_o == $past(cnt_o) + CNT_W'(1)));

  assert_two_phase_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !comm_i |=> ($countones(gate_hi_o) <= 1 && $countones(gate_lo_o) <= 1));

  assert_one_sink_on_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comm_i && !sector_i[0] && sector_i != 3'd0) |=> ($countones(gate_lo_o) >= 1));

endmodule

bind bldc_chop_gen bldc_chop_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sector_i  (sector_i),
  .comm_i    (comm_i),
  .cnt_o     (cnt_o),
  .gate_hi_o (gate_hi_o),
  .gate_lo_o (gate_lo_o)
);

// File: tb/sim_bldc_chop_gen.sv
`timescale 1ns/1ps
module sim_bldc_chop_gen;

  localparam int W  = 16;
  localparam int RP = 6;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic [W-1:0] period_i, ton_norm_i, ton_comm_even_i, ton_comm_odd_i;
  logic [2:0]   sector_i;
  logic         comm_i;
  logic [W-1:0] cnt_o;
  logic [2:0]   gate_hi_o, gate_lo_o;
  logic         chop_edge_o;

  always #2 clk_i = ~clk_i;

  bldc_chop_gen #(.CNT_W(W), .RST_PERIOD(RP)) u0 (.*);

  typedef struct {
    int       cnt;
    bit [2:0] hi;
    bit [2:0] lo;
    bit       edg;
  } exp_t;

  exp_t  q[$];
  int    n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  // sector tables: index = sector code, phase 0=A 1=B 2=C
  int src_tab[8] = '{0, 0, 0, 1, 1, 2, 2, 0};
  int snk_tab[8] = '{0, 1, 2, 2, 0, 0, 1, 0};

  int m_cnt, m_per, m_norm, m_even, m_odd, m_ton, m_last, m_s, m_ps;
  bit m_chop, m_ch;
  exp_t m_e;

  // reference model: expected outputs after each edge
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_cnt = 0; m_per = RP; m_norm = 0; m_even = 0; m_odd = 0; m_chop = 0;
      q.delete();
    end else begin
      if (!comm_i)          m_ton = m_norm;
      else if (!sector_i[0]) m_ton = m_even;
      else                  m_ton = m_odd;
      m_ch = (m_cnt < m_ton);
      m_e.hi = 3'b000; m_e.lo = 3'b000;
      m_s = int'(sector_i);
      m_ps = (m_s == 1) ? 6 : m_s - 1;
      if (m_s >= 1 && m_s <= 6) begin
        if (!comm_i) begin
          m_e.hi[src_tab[m_s]] = m_ch; m_e.lo[snk_tab[m_s]] = 1'b1;
        end else if (m_s % 2 == 0) begin
          m_e.hi[src_tab[m_s]] = m_ch; m_e.lo[snk_tab[m_ps]] = m_ch;
          m_e.lo[snk_tab[m_s]] = 1'b1;
        end else begin
          m_e.lo[snk_tab[m_s]] = m_ch; m_e.hi[src_tab[m_ps]] = m_ch;
          m_e.hi[src_tab[m_s]] = 1'b1;
        end
      end
      m_e.edg = (m_ch != m_chop);
      m_chop = m_ch;
      m_last = (m_per == 0) ? 0 : m_per - 1;
      if (m_cnt == m_last) begin
        m_cnt = 0; m_per = int'(period_i); m_norm = int'(ton_norm_i);
        m_even = int'(ton_comm_even_i); m_odd = int'(ton_comm_odd_i);
      end else begin
        m_cnt = m_cnt + 1;
      end
      m_e.cnt = m_cnt;
      q.push_back(m_e);
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(cur_req, "cnt_o", int'(cnt_o), e.cnt);
      chk(cur_req, "gate_hi_o", int'(gate_hi_o), int'(e.hi));
      chk(cur_req, "gate_lo_o", int'(gate_lo_o), int'(e.lo));
      chk((cur_req == "R9") ? "R9" : cur_req, "chop_edge_o", int'(chop_edge_o), int'(e.edg));
      chk("R8", "hi&lo overlap", int'(gate_hi_o & gate_lo_o), 0);
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; period_i = 16'd8; sector_i = 3'd1; comm_i = 1'b0;
    ton_norm_i = 16'd3; ton_comm_even_i = 16'd5; ton_comm_odd_i = 16'd2;
    run(3);
    // R7 reset state, R1 carrier at zero, R9 no strobe
    chk("R7", "reset gate_hi_o", int'(gate_hi_o), 0);
    chk("R7", "reset gate_lo_o", int'(gate_lo_o), 0);
    chk("R1", "reset cnt_o", int'(cnt_o), 0);
    chk("R9", "reset chop_edge_o", int'(chop_edge_o), 0);
    rst_ni = 1'b1;

    cur_req = "R2"; run(20);           // first period uses RST_PERIOD, then 8
    cur_req = "R4";
    for (int s = 1; s <= 6; s++) begin sector_i = 3'(s); run(11); end
    cur_req = "R9"; ton_norm_i = 16'd4; run(20);
    cur_req = "R5"; comm_i = 1'b1;
    for (int s = 2; s <= 6; s += 2) begin sector_i = 3'(s); run(13); end
    cur_req = "R6";
    for (int s = 1; s <= 5; s += 2) begin sector_i = 3'(s); run(13); end
    cur_req = "R10";
    for (int i = 0; i < 12; i++) begin
      comm_i = ~comm_i; sector_i = 3'((i % 6) + 1); run(3);
    end
    cur_req = "R7"; comm_i = 1'b0;
    sector_i = 3'd0; run(10); sector_i = 3'd7; run(10);
    comm_i = 1'b1; sector_i = 3'd0; run(10); sector_i = 3'd7; run(10);
    cur_req = "R3"; comm_i = 1'b0; sector_i = 3'd3;
    ton_norm_i = 16'd0; run(20);
    ton_norm_i = 16'd9; run(20);
    ton_norm_i = 16'd8; run(20);
    cur_req = "R2"; ton_norm_i = 16'd5; run(12);
    while (cnt_o != 16'd3) @(negedge clk_i);
    ton_norm_i = 16'd1; ton_comm_even_i = 16'd7; run(20);
    cur_req = "R1";
    period_i = 16'd1; run(20);
    period_i = 16'd0; run(10);
    period_i = 16'd5; run(20);
    period_i = 16'd8; ton_norm_i = 16'd6; run(20);
    run(2);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule